// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block is the control sequencer of a small 16-bit segmented CPU that moves control into and out of handler routines. It accepts three request classes, each tagged with an 8-bit vector number: exceptions raised by faulting instructions, software traps issued by an explicit instruction, and external hardware interrupts. To enter a handler, it saves the flags, the code segment and the instruction pointer on the stack. It then fetches the handler's far pointer from a vector table at the bottom of physical memory and hands back the new code segment, instruction pointer, stack pointer and flags.

A return request runs the reverse sequence. It pops the saved instruction pointer, code segment and flags, so all three registers come back together.

All memory traffic goes through one word-wide request/acknowledge port. The architectural registers reach the sequencer only as input ports. Its results appear on output ports that are valid while `done_o` is high.

Top module: `irq_seq`

## Requirements
- R1: The handler pointer for vector n is read as two words: the offset at byte address n*4 first, then the segment at n*4+2. When `done_o` is high, `ip_o` equals the offset and `cs_o` equals the segment.
- R2: Entry writes three words in this order: flags, then code segment, then instruction pointer. Before each write SP is decremented by 2, and the word goes to physical address SS*16+SP, taken modulo 2^20. At done, `sp_o` equals the incoming SP minus 6.
- R3: After a hardware interrupt entry, `flags_o` is the incoming flags with bit 9 (interrupt enable) cleared. After a trap or exception entry, `flags_o` equals the incoming flags. In every case the pushed flags word is the unmodified incoming value.
- R4: A hardware request is accepted only when `hw_req_i`, `instr_boundary_i` and `flags_i[9]` are all high. Traps and exceptions are accepted whatever the values of bit 9 and the boundary input.
- R5: When requests compete for the same start cycle, the order is exception, then trap, then return, then hardware interrupt.
- R6: Acceptance of a hardware request produces exactly one cycle of `hw_ack_o`. The vector serviced is the `hw_vec_i` value present when the request was accepted.
- R7: A return reads three words, each at SS*16+SP, and adds 2 to SP after each read. The words are taken as instruction pointer, then code segment, then flags. At done, `ip_o`, `cs_o` and `flags_o` hold those words and `sp_o` equals the incoming SP plus 6. A return performs no writes.
- R8: While `mem_req_o` is high and `mem_ack_i` has not arrived, `mem_addr_o`, `mem_wdata_o` and `mem_we_o` stay unchanged.
- R9: After reset, `busy_o`, `done_o`, `mem_req_o` and `hw_ack_o` are low. `busy_o` is high from acceptance through the cycle in which `done_o` pulses for exactly one cycle, and memory requests occur only while busy.
- R10: A trap, exception or return pulse that arrives while the sequencer is busy is held and serviced after the current sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_boundary_i | input | 1 | High when the core sits between instructions |
| exc_req_i | input | 1 | Exception request pulse |
| exc_vec_i | input | 8 | Exception vector number |
| trap_req_i | input | 1 | Software trap request pulse |
| trap_vec_i | input | 8 | Trap vector number |
| ret_req_i | input | 1 | Handler return request pulse |
| hw_req_i | input | 1 | Hardware interrupt request level |
| hw_vec_i | input | 8 | Hardware interrupt vector number |
| hw_ack_o | output | 1 | One-cycle acknowledge of a hardware request |
| flags_i | input | 16 | Current flags register |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| flags_o | output | 16 | New flags, valid with done |
| cs_o | output | 16 | New code segment, valid with done |
| ip_o | output | 16 | New instruction pointer, valid with done |
| sp_o | output | 16 | New stack pointer, valid with done |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the outputs are valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 16 | Read data, valid with ack |

## Verification
If the latched request class were wrong, the failure would show within one sequence. The interrupt-enable bit in `flags_o` would come out wrong at done, or the pointer fetched would belong to another vector. If the working stack pointer were corrupted, it would show at the next memory request. The push or pop address would move off the SS*16+SP progression, and `sp_o` would differ from the incoming SP by something other than 6. If a pending request flag were lost or stuck, the fault would surface at the next idle cycle: a handler would be skipped, one would be entered twice, or the service order would differ from the priority.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_RD_OFF, S_RD_SEG,
    S_POP_IP, S_POP_CS, S_POP_FL, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {K_EXC, K_TRAP, K_RET, K_HW} req_kind_e;
endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb import irq_seq_pkg::*; #(
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          boundary_i,
  input  logic          if_i,
  input  logic          exc_req_i,
  input  logic [VW-1:0] exc_vec_i,
  input  logic          trap_req_i,
  input  logic [VW-1:0] trap_vec_i,
  input  logic          ret_req_i,
  input  logic          hw_req_i,
  input  logic [VW-1:0] hw_vec_i,
  output logic          start_o,
  output req_kind_e     kind_o,
  output logic [VW-1:0] vec_o,
  output logic          hw_ack_o
);
  logic          exc_p, trap_p, ret_p, ack_q;
  logic [VW-1:0] exc_v, trap_v;
  logic          exc_any, trap_any, ret_any, hw_ok;
  logic [VW-1:0] exc_cur, trap_cur;

  // a pulse arriving this cycle competes alongside held ones
  assign exc_any  = exc_p | exc_req_i;
  assign trap_any = trap_p | trap_req_i;
  assign ret_any  = ret_p | ret_req_i;
  assign exc_cur  = exc_req_i ? exc_vec_i : exc_v;
  assign trap_cur = trap_req_i ? trap_vec_i : trap_v;
  assign hw_ok    = hw_req_i & boundary_i & if_i;

  always_comb begin
    kind_o = K_HW;
    vec_o  = hw_vec_i;
    if (exc_any) begin
      kind_o = K_EXC;
      vec_o  = exc_cur;
    end else if (trap_any) begin
      kind_o = K_TRAP;
      vec_o  = trap_cur;
    end else if (ret_any) begin
      kind_o = K_RET;
      vec_o  = '0;
    end
  end

  assign start_o  = idle_i & (exc_any | trap_any | ret_any | hw_ok);
  assign hw_ack_o = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_p  <= 1'b0;
      trap_p <= 1'b0;
      ret_p  <= 1'b0;
      exc_v  <= '0;
      trap_v <= '0;
      ack_q  <= 1'b0;
    end else begin
      exc_p  <= exc_any & ~(start_o & (kind_o == K_EXC));
      trap_p <= trap_any & ~(start_o & (kind_o == K_TRAP));
      ret_p  <= ret_any & ~(start_o & (kind_o == K_RET));
      if (exc_req_i)  exc_v  <= exc_vec_i;
      if (trap_req_i) trap_v <= trap_vec_i;
      ack_q  <= start_o & (kind_o == K_HW);
    end
  end
endmodule

// File: rtl/irq_seq_addr.sv
module irq_seq_addr import irq_seq_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int VW = 8
) (
  input  seq_state_e    state_i,
  input  logic [DW-1:0] ss_i,
  input  logic [DW-1:0] sp_i,
  input  logic [VW-1:0] vec_i,
  output logic [AW-1:0] addr_o
);
  localparam int SH = AW - DW;
  localparam int PADW = AW - VW - 2;

  logic [DW-1:0] sp_dec;
  logic [AW-1:0] stk_base, tbl_base;

  assign sp_dec   = sp_i - DW'(2);
  assign stk_base = {ss_i, {SH{1'b0}}};
  assign tbl_base = {{PADW{1'b0}}, vec_i, 2'b00};

  always_comb begin
    unique case (state_i)
      S_PUSH_FL, S_PUSH_CS, S_PUSH_IP:
        addr_o = stk_base + {{SH{1'b0}}, sp_dec};
      S_POP_IP, S_POP_CS, S_POP_FL:
        addr_o = stk_base + {{SH{1'b0}}, sp_i};
      S_RD_OFF: addr_o = tbl_base;
      S_RD_SEG: addr_o = tbl_base + AW'(2);
      default:  addr_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq import irq_seq_pkg::*; #(
  parameter int DW     = 16,
  parameter int AW     = 20,
  parameter int VW     = 8,
  parameter int IF_BIT = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_boundary_i,
  input  logic          exc_req_i,
  input  logic [VW-1:0] exc_vec_i,
  input  logic          trap_req_i,
  input  logic [VW-1:0] trap_vec_i,
  input  logic          ret_req_i,
  input  logic          hw_req_i,
  input  logic [VW-1:0] hw_vec_i,
  output logic          hw_ack_o,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] ss_i,
  input  logic [DW-1:0] sp_i,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] sp_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [DW-1:0] WSTEP = DW'(2);

  seq_state_e    state_q;
  req_kind_e     kind_q, arb_kind;
  logic [VW-1:0] vec_q, arb_vec;
  logic [DW-1:0] fl_q, cs_q, ip_q, ss_q, sp_q;
  logic          start, idle, is_push, is_pop;

  assign idle = (state_q == S_IDLE);

  irq_seq_arb #(.VW(VW)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle),
    .boundary_i (instr_boundary_i),
    .if_i       (flags_i[IF_BIT]),
    .exc_req_i  (exc_req_i),
    .exc_vec_i  (exc_vec_i),
    .trap_req_i (trap_req_i),
    .trap_vec_i (trap_vec_i),
    .ret_req_i  (ret_req_i),
    .hw_req_i   (hw_req_i),
    .hw_vec_i   (hw_vec_i),
    .start_o    (start),
    .kind_o     (arb_kind),
    .vec_o      (arb_vec),
    .hw_ack_o   (hw_ack_o)
  );

  irq_seq_addr #(.DW(DW), .AW(AW), .VW(VW)) u_addr (
    .state_i (state_q),
    .ss_i    (ss_q),
    .sp_i    (sp_q),
    .vec_i   (vec_q),
    .addr_o  (mem_addr_o)
  );

  assign is_push = (state_q == S_PUSH_FL) || (state_q == S_PUSH_CS) ||
                   (state_q == S_PUSH_IP);
  assign is_pop  = (state_q == S_POP_IP) || (state_q == S_POP_CS) ||
                   (state_q == S_POP_FL);

  assign mem_req_o = is_push || is_pop ||
                     (state_q == S_RD_OFF) || (state_q == S_RD_SEG);
  assign mem_we_o  = is_push;

  always_comb begin
    unique case (state_q)
      S_PUSH_FL: mem_wdata_o = fl_q;
      S_PUSH_CS: mem_wdata_o = cs_q;
      S_PUSH_IP: mem_wdata_o = ip_q;
      default:   mem_wdata_o = '0;
    endcase
  end

  assign busy_o  = ~idle;
  assign done_o  = (state_q == S_DONE);
  assign flags_o = fl_q;
  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign sp_o    = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_EXC;
      vec_q   <= '0;
      fl_q    <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          kind_q  <= arb_kind;
          vec_q   <= arb_vec;
          fl_q    <= flags_i;
          cs_q    <= cs_i;
          ip_q    <= ip_i;
          ss_q    <= ss_i;
          sp_q    <= sp_i;
          state_q <= (arb_kind == K_RET) ? S_POP_IP : S_PUSH_FL;
        end
        S_PUSH_FL: if (mem_ack_i) begin
          sp_q <= sp_q - WSTEP;
          // original flags already on the stack; mask only after the write
          if (kind_q == K_HW) fl_q[IF_BIT] <= 1'b0;
          state_q <= S_PUSH_CS;
        end
        S_PUSH_CS: if (mem_ack_i) begin
          sp_q    <= sp_q - WSTEP;
          state_q <= S_PUSH_IP;
        end
        S_PUSH_IP: if (mem_ack_i) begin
          sp_q    <= sp_q - WSTEP;
          state_q <= S_RD_OFF;
        end
        S_RD_OFF: if (mem_ack_i) begin
          ip_q    <= mem_rdata_i;
          state_q <= S_RD_SEG;
        end
        S_RD_SEG: if (mem_ack_i) begin
          cs_q    <= mem_rdata_i;
          state_q <= S_DONE;
        end
        S_POP_IP: if (mem_ack_i) begin
          ip_q    <= mem_rdata_i;
          sp_q    <= sp_q + WSTEP;
          state_q <= S_POP_CS;
        end
        S_POP_CS: if (mem_ack_i) begin
          cs_q    <= mem_rdata_i;
          sp_q    <= sp_q + WSTEP;
          state_q <= S_POP_FL;
        end
        S_POP_FL: if (mem_ack_i) begin
          fl_q    <= mem_rdata_i;
          sp_q    <= sp_q + WSTEP;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int DW     = 16,
  parameter int AW     = 20,
  parameter int IF_BIT = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_boundary_i,
  input logic          hw_req_i,
  input logic [DW-1:0] flags_i,
  input logic          hw_ack_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i
);
  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_wdata_o) && $stable(mem_we_o)));
  // R9
  mem_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_ack_o |=> !hw_ack_o);
  // R6
  ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_ack_o |-> busy_o);
  // R4
  hw_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hw_ack_o) |-> $past(hw_req_i && instr_boundary_i && flags_i[IF_BIT]));
endmodule

bind irq_seq irq_seq_chk #(.DW(DW), .AW(AW), .IF_BIT(IF_BIT)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .instr_boundary_i (instr_boundary_i),
  .hw_req_i         (hw_req_i),
  .flags_i          (flags_i),
  .hw_ack_o         (hw_ack_o),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .mem_req_o        (mem_req_o),
  .mem_we_o         (mem_we_o),
  .mem_addr_o       (mem_addr_o),
  .mem_wdata_o      (mem_wdata_o),
  .mem_ack_i        (mem_ack_i)
);

// File: tb/tb_irq_seq.sv
`timescale 1ns/1ps
module tb_irq_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_boundary_i = 1'b0;
  logic        exc_req_i = 1'b0, trap_req_i = 1'b0, ret_req_i = 1'b0, hw_req_i = 1'b0;
  logic [7:0]  exc_vec_i = '0, trap_vec_i = '0, hw_vec_i = '0;
  logic        hw_ack_o;
  logic [15:0] flags_i = '0, cs_i = '0, ip_i = '0, ss_i = '0, sp_i = '0;
  logic [15:0] flags_o, cs_o, ip_o, sp_o;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;

  always #10 clk_i = ~clk_i;

  irq_seq dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] smem [int];
  logic [19:0] wr_a [8];
  logic [15:0] wr_d [8];
  logic [19:0] rd_a [8];
  int wr_n = 0, rd_n = 0, dly = 0, hold_err = 0;
  logic        prev_wait = 1'b0;
  logic [19:0] prev_a = '0;

  function automatic logic [15:0] tbl_off(input logic [7:0] n);
    return {n, ~n} ^ 16'h5a3c;
  endfunction
  function automatic logic [15:0] tbl_seg(input logic [7:0] n);
    return {~n, n} + 16'h0100;
  endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: random latency, single-cycle ack
  always @(negedge clk_i) begin
    cycles++;
    if (prev_wait && mem_req_o && mem_addr_o != prev_a) hold_err++;
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      prev_wait = 1'b0;
    end else if (mem_req_o) begin
      if (dly == 0) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          smem[int'(mem_addr_o)] = mem_wdata_o;
          if (wr_n < 8) begin wr_a[wr_n] = mem_addr_o; wr_d[wr_n] = mem_wdata_o; end
          wr_n++;
        end else begin
          if (mem_addr_o < 20'd1024)
            mem_rdata_i = mem_addr_o[1] ? tbl_seg(mem_addr_o[9:2]) : tbl_off(mem_addr_o[9:2]);
          else if (smem.exists(int'(mem_addr_o)))
            mem_rdata_i = smem[int'(mem_addr_o)];
          else
            mem_rdata_i = 16'h0;
          if (rd_n < 8) rd_a[rd_n] = mem_addr_o;
          rd_n++;
        end
        dly = $urandom % 4;
        prev_wait = 1'b0;
      end else begin
        dly--;
        prev_wait = 1'b1;
        prev_a = mem_addr_o;
      end
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 400) begin @(negedge clk_i); n++; end
    chk(done_o, req, "done reached", 32'(done_o), 1);
    chk(busy_o, "R9", "busy with done", 32'(busy_o), 1);
  endtask

  task automatic after_done();
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R9", "done single pulse", {done_o, busy_o}, 0);
  endtask

  task automatic set_regs(input logic [15:0] f, c, i, s, p);
    flags_i = f; cs_i = c; ip_i = i; ss_i = s; sp_i = p;
  endtask

  // kind: 0 exception, 1 trap, 3 hardware
  task automatic entry(input int kind, input logic [7:0] v, input logic [15:0] f,
                       input logic [15:0] c, input logic [15:0] i,
                       input logic [15:0] s, input logic [15:0] p);
    logic [15:0] fexp;
    @(negedge clk_i);
    wr_n = 0; rd_n = 0;
    set_regs(f, c, i, s, p);
    if (kind == 0) begin exc_req_i = 1; exc_vec_i = v; end
    else if (kind == 1) begin trap_req_i = 1; trap_vec_i = v; end
    else begin hw_req_i = 1; hw_vec_i = v; instr_boundary_i = 1; end
    @(negedge clk_i);
    exc_req_i = 0; trap_req_i = 0;
    if (kind == 3) begin
      int n = 0;
      while (!hw_ack_o && n < 50) begin @(negedge clk_i); n++; end
      chk(hw_ack_o, "R6", "ack seen", 32'(hw_ack_o), 1);
      hw_req_i = 0; hw_vec_i = ~v;
      @(negedge clk_i);
      chk(!hw_ack_o, "R6", "ack one cycle", 32'(hw_ack_o), 0);
    end
    wait_done("R1");
    fexp = (kind == 3) ? (f & ~16'h0200) : f;
    chk(cs_o == tbl_seg(v), "R1", "cs", cs_o, tbl_seg(v));
    chk(ip_o == tbl_off(v), "R1", "ip", ip_o, tbl_off(v));
    chk(rd_n == 2 && rd_a[0] == {10'h0, v, 2'b00} && rd_a[1] == {10'h0, v, 2'b10},
        "R1", "table read order", {rd_a[0][11:0], rd_a[1][11:0]}, {10'h0, v, 2'b00, 10'h0, v, 2'b10});
    chk(sp_o == p - 16'd6, "R2", "sp after push", sp_o, p - 16'd6);
    chk(wr_n == 3 && wr_a[0] == phys(s, p - 16'd2) && wr_a[1] == phys(s, p - 16'd4) &&
        wr_a[2] == phys(s, p - 16'd6), "R2", "push addresses", wr_a[0], phys(s, p - 16'd2));
    chk(wr_d[0] == f && wr_d[1] == c && wr_d[2] == i, "R2", "push data",
        {wr_d[0], wr_d[2]}, {f, i});
    chk(flags_o == fexp, "R3", "flags out", flags_o, fexp);
    after_done();
  endtask

  task automatic do_return(input logic [15:0] f, c, i, s, p);
    @(negedge clk_i);
    wr_n = 0; rd_n = 0;
    set_regs(16'h0, 16'h0, 16'h0, s, p - 16'd6);
    ret_req_i = 1;
    @(negedge clk_i);
    ret_req_i = 0;
    wait_done("R7");
    chk(ip_o == i && cs_o == c && flags_o == f, "R7", "restored regs",
        {cs_o, ip_o}, {c, i});
    chk(flags_o == f, "R7", "restored flags", flags_o, f);
    chk(sp_o == p, "R7", "sp after pop", sp_o, p);
    chk(wr_n == 0 && rd_n == 3 && rd_a[0] == phys(s, p - 16'd6) &&
        rd_a[2] == phys(s, p - 16'd2), "R7", "pop addresses", rd_a[0], phys(s, p - 16'd6));
    after_done();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !hw_ack_o, "R9", "reset outputs",
        {busy_o, done_o, mem_req_o, hw_ack_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R4: masked by flag, then by boundary
    set_regs(16'h0000, 16'h1000, 16'h0020, 16'h2000, 16'h0100);
    hw_req_i = 1; hw_vec_i = 8'h21; instr_boundary_i = 1;
    begin
      bit seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk_i);
        if (busy_o || hw_ack_o) seen = 1;
      end
      chk(!seen, "R4", "hw masked by flag", 32'(seen), 0);
      flags_i = 16'h0200; instr_boundary_i = 0; seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk_i);
        if (busy_o || hw_ack_o) seen = 1;
      end
      chk(!seen, "R4", "hw waits for boundary", 32'(seen), 0);
    end
    hw_req_i = 0;

    // R4: trap and exception taken with flag clear
    entry(1, 8'h03, 16'h0046, 16'h1111, 16'h2222, 16'h3000, 16'h0400);
    do_return(16'h0046, 16'h1111, 16'h2222, 16'h3000, 16'h0400);
    entry(0, 8'h00, 16'h0000, 16'h0aaa, 16'h0bbb, 16'h3000, 16'h0001);
    entry(3, 8'hff, 16'h0202, 16'h4444, 16'h5555, 16'hfff0, 16'h0000);

    // R5: simultaneous exception, trap, hardware
    @(negedge clk_i);
    set_regs(16'h0200, 16'h1234, 16'h5678, 16'h4000, 16'h0800);
    exc_req_i = 1; exc_vec_i = 8'h10; trap_req_i = 1; trap_vec_i = 8'h20;
    hw_req_i = 1; hw_vec_i = 8'h30; instr_boundary_i = 1;
    @(negedge clk_i);
    exc_req_i = 0; trap_req_i = 0;
    wait_done("R5");
    chk(cs_o == tbl_seg(8'h10), "R5", "exception first", cs_o, tbl_seg(8'h10));
    after_done();
    wait_done("R5");
    chk(cs_o == tbl_seg(8'h20), "R5", "trap second", cs_o, tbl_seg(8'h20));
    after_done();
    begin
      int n = 0;
      while (!hw_ack_o && n < 50) begin @(negedge clk_i); n++; end
    end
    hw_req_i = 0;
    wait_done("R5");
    chk(cs_o == tbl_seg(8'h30), "R5", "hardware last", cs_o, tbl_seg(8'h30));
    after_done();

    // R10: exception pulsed while busy with a trap
    @(negedge clk_i);
    trap_req_i = 1; trap_vec_i = 8'h44;
    @(negedge clk_i);
    trap_req_i = 0;
    @(negedge clk_i);
    chk(busy_o, "R10", "busy during trap", 32'(busy_o), 1);
    exc_req_i = 1; exc_vec_i = 8'h55;
    @(negedge clk_i);
    exc_req_i = 0;
    wait_done("R10");
    chk(cs_o == tbl_seg(8'h44), "R10", "trap finishes", cs_o, tbl_seg(8'h44));
    after_done();
    wait_done("R10");
    chk(ip_o == tbl_off(8'h55), "R10", "held exception serviced", ip_o, tbl_off(8'h55));
    after_done();

    // random entry/return pairs
    for (int it = 0; it < 40; it++) begin
      int kind;
      logic [15:0] f, c, i, s, p;
      logic [7:0] v;
      kind = $urandom % 3; if (kind == 2) kind = 3;
      v = 8'($urandom);
      f = 16'($urandom); if (kind == 3) f[9] = 1'b1;
      c = 16'($urandom); i = 16'($urandom);
      s = 16'h0100 + 16'($urandom % 16'h7000);
      p = 16'($urandom) & 16'hfffe;
      entry(kind, v, f, c, i, s, p);
      do_return(f, c, i, s, p);
    end

    chk(hold_err == 0, "R8", "address held while waiting", hold_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #25; rst_ni = rst_ni;
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule